// File: doc/BRIEF.md
# Packed-BCD Timecode Frame Counter

This block holds a running time-of-day value split into hours, minutes, seconds and frames, each kept as one packed-BCD byte: the tens digit sits in bits [7:4] and the units digit in bits [3:0]. A one-cycle `adv` strobe moves the count forward by exactly one frame. The count runs at 30 frames per second, and carries pass from frames up through seconds, minutes and hours. After 23:59:59:29 the count returns to 00:00:00:00.

A serializer that sends one 80-bit timecode word per frame reads the four output bytes at the frame boundary, which is the moment it returns to bit 0. It then pulses `adv` so that the next word carries the next frame number. A synchronous reset clears the count. A synchronous load presets all four bytes at once, for example to line the count up with a wall clock.

Top module: `tc_frame_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, all four outputs become 8'h00 after that edge. Reset takes priority over `load` and `adv`.
- R2: When `rst`, `load` and `adv` are all low, all four outputs keep their values from one edge to the next.
- R3: On an advance, a frames units digit below 9 increments by one. A units digit of 9 goes to 0 and the tens digit increments (8'h09 becomes 8'h10, and 8'h19 becomes 8'h20).
- R4: On an advance with frames at 8'h29, frames becomes 8'h00 and seconds advances by one. When frames is not at 8'h29, seconds, minutes and hours do not change.
- R5: Seconds follow the same units-to-tens carry, so 8'h09 becomes 8'h10. Seconds wrap from 8'h59 to 8'h00, and minutes advance only on that wrap.
- R6: Minutes carry from units to tens and wrap from 8'h59 to 8'h00. Hours advance only on that wrap.
- R7: Hours carry from units to tens (8'h09 becomes 8'h10, and 8'h19 becomes 8'h20) and wrap from 8'h23 to 8'h00. An advance at 23:59:59:29 gives 00:00:00:00.
- R8: When `load` is high and `rst` is low, the four `set_*` bytes are copied to the outputs at that edge, even if `adv` is high in the same cycle.
- R9: Outputs change only at the rising clock edge. The new value is visible in the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Synchronous preset strobe |
| adv | input | 1 | One-frame advance strobe |
| set_hours | input | 8 | Preset hours, packed BCD |
| set_minutes | input | 8 | Preset minutes, packed BCD |
| set_seconds | input | 8 | Preset seconds, packed BCD |
| set_frames | input | 8 | Preset frames, packed BCD |
| hours | output | 8 | Hours, packed BCD 00-23 |
| minutes | output | 8 | Minutes, packed BCD 00-59 |
| seconds | output | 8 | Seconds, packed BCD 00-59 |
| frames | output | 8 | Frames, packed BCD 00-29 |

## Verification
A run of consecutive advances from zero walks frames through each units-to-tens step and through the 29-to-00 wrap into seconds. This separates a binary wrap from a decimal carry and shows whether the frame limit is 29. Presets placed one frame before each field's boundary show whether every carry lands in the right field and whether the field above it stays still. These presets are 00:00:09:29, 00:00:59:29, 00:59:59:29, 09:59:59:29, 19:59:59:29 and 23:59:59:29. Idle stretches, a load issued together with `adv`, and a reset issued together with `load` show the hold behaviour and the order of priority among the controls.

// File: rtl/tc_frame_counter.sv
module tc_frame_counter (
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       adv,
  input  logic [7:0] set_hours,
  input  logic [7:0] set_minutes,
  input  logic [7:0] set_seconds,
  input  logic [7:0] set_frames,
  output logic [7:0] hours,
  output logic [7:0] minutes,
  output logic [7:0] seconds,
  output logic [7:0] frames
);

  // returns {wrapped, next value}
  function automatic logic [8:0] bump(input logic [7:0] v, input logic [7:0] last);
    if (v == last)
      bump = 9'h100;
    else if (v[3:0] == 4'd9)
      bump = {1'b0, v[7:4] + 4'd1, 4'd0};
    else
      bump = {1'b0, v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [8:0] fr_n, se_n, mi_n, hr_n;
  logic       c_se, c_mi, c_hr;

  assign fr_n = bump(frames,  8'h29);
  assign se_n = bump(seconds, 8'h59);
  assign mi_n = bump(minutes, 8'h59);
  assign hr_n = bump(hours,   8'h23);

  assign c_se = fr_n[8];
  assign c_mi = c_se & se_n[8];
  assign c_hr = c_mi & mi_n[8];

  always_ff @(posedge clk) begin
    if (rst) begin
      hours   <= 8'h00;
      minutes <= 8'h00;
      seconds <= 8'h00;
      frames  <= 8'h00;
    end else if (load) begin
      hours   <= set_hours;
      minutes <= set_minutes;
      seconds <= set_seconds;
      frames  <= set_frames;
    end else if (adv) begin
      frames <= fr_n[7:0];
      if (c_se) seconds <= se_n[7:0];
      if (c_mi) minutes <= mi_n[7:0];
      if (c_hr) hours   <= hr_n[7:0];
    end
  end

endmodule

// File: rtl/tc_frame_counter_chk.sv
module tc_frame_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       load,
  input logic       adv,
  input logic [7:0] set_hours,
  input logic [7:0] set_minutes,
  input logic [7:0] set_seconds,
  input logic [7:0] set_frames,
  input logic [7:0] hours,
  input logic [7:0] minutes,
  input logic [7:0] seconds,
  input logic [7:0] frames
);

  assert_reset_zero_R1: assert property (@(posedge clk)
    rst |=> (hours == 8'h00 && minutes == 8'h00 && seconds == 8'h00 && frames == 8'h00));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (!load && !adv) |=> ($stable(hours) && $stable(minutes) && $stable(seconds) && $stable(frames)));

  assert_frame_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && frames == 8'h29) |=> (frames == 8'h00));

  assert_upper_still_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && frames != 8'h29) |=> ($stable(seconds) && $stable(minutes) && $stable(hours)));

  assert_full_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && adv && hours == 8'h23 && minutes == 8'h59 && seconds == 8'h59 && frames == 8'h29)
    |=> (hours == 8'h00 && minutes == 8'h00 && seconds == 8'h00 && frames == 8'h00));

  assert_load_wins_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (hours == $past(set_hours) && minutes == $past(set_minutes) &&
              seconds == $past(set_seconds) && frames == $past(set_frames)));

endmodule

bind tc_frame_counter tc_frame_counter_chk u_chk (
  .clk(clk), .rst(rst), .load(load), .adv(adv),
  .set_hours(set_hours), .set_minutes(set_minutes),
  .set_seconds(set_seconds), .set_frames(set_frames),
  .hours(hours), .minutes(minutes), .seconds(seconds), .frames(frames)
);

// File: tb/test_tc_frame_counter.sv
module test_tc_frame_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DAY_FRAMES = 24 * 60 * 60 * 30;

  logic       clk = 1'b0;
  logic       rst, load, adv;
  logic [7:0] set_hours, set_minutes, set_seconds, set_frames;
  logic [7:0] hours, minutes, seconds, frames;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tc_frame_counter i_tc_frame_counter (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .set_hours(set_hours), .set_minutes(set_minutes),
    .set_seconds(set_seconds), .set_frames(set_frames),
    .hours(hours), .minutes(minutes), .seconds(seconds), .frames(frames)
  );

  function automatic logic [7:0] to_bcd(input int v);
    return 8'(((v / 10) << 4) | (v % 10));
  endfunction

  // frame index within the day -> {hh,mm,ss,ff} packed BCD
  function automatic logic [31:0] idx_to_tc(input int idx);
    int i, f, s, m, h;
    i = idx % DAY_FRAMES;
    f = i % 30;
    s = (i / 30) % 60;
    m = (i / 1800) % 60;
    h = i / 108000;
    return {to_bcd(h), to_bcd(m), to_bcd(s), to_bcd(f)};
  endfunction

  function automatic int tc_idx(input int h, input int m, input int s, input int f);
    return ((h * 60 + m) * 60 + s) * 30 + f;
  endfunction

  task automatic check(input string req, input logic [31:0] exp);
    logic [31:0] act;
    act = {hours, minutes, seconds, frames};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic do_load(input int h, input int m, input int s, input int f);
    @(negedge clk);
    load = 1'b1;
    set_hours = to_bcd(h); set_minutes = to_bcd(m);
    set_seconds = to_bcd(s); set_frames = to_bcd(f);
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic step_once();
    @(negedge clk);
    adv = 1'b1;
    @(negedge clk);
    adv = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 32'h0);
  endtask

  task automatic t_run_from_zero();
    t_reset();
    for (int k = 1; k <= 40; k++) begin
      step_once();
      check(k < 30 ? "R3 frame digit carry" : "R4 frame wrap into seconds", idx_to_tc(k));
    end
  endtask

  task automatic t_boundary(input string req, input int h, input int m, input int s, input int f);
    do_load(h, m, s, f);
    check("R8 preset", idx_to_tc(tc_idx(h, m, s, f)));
    step_once();
    check(req, idx_to_tc(tc_idx(h, m, s, f) + 1));
  endtask

  task automatic t_hold();
    logic [31:0] snap;
    do_load(12, 34, 56, 17);
    snap = {hours, minutes, seconds, frames};
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check("R2 idle hold", snap);
    end
  endtask

  task automatic t_timing();
    do_load(3, 4, 5, 6);
    @(negedge clk);
    adv = 1'b1;
    #1;
    check("R9 no change before edge", idx_to_tc(tc_idx(3, 4, 5, 6)));
    @(negedge clk);
    adv = 1'b0;
    check("R9 change after edge", idx_to_tc(tc_idx(3, 4, 5, 7)));
  endtask

  task automatic t_load_priority();
    do_load(1, 1, 1, 1);
    @(negedge clk);
    load = 1'b1; adv = 1'b1;
    set_hours = 8'h23; set_minutes = 8'h59; set_seconds = 8'h59; set_frames = 8'h29;
    @(negedge clk);
    load = 1'b0; adv = 1'b0;
    check("R8 load over advance", 32'h23595929);
  endtask

  task automatic t_reset_priority();
    do_load(7, 7, 7, 7);
    @(negedge clk);
    rst = 1'b1; load = 1'b1; adv = 1'b1;
    set_hours = 8'h11; set_minutes = 8'h22; set_seconds = 8'h33; set_frames = 8'h14;
    @(negedge clk);
    rst = 1'b0; load = 1'b0; adv = 1'b0;
    check("R1 reset over load", 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst = 1'b1; load = 1'b0; adv = 1'b0;
    set_hours = 8'h00; set_minutes = 8'h00; set_seconds = 8'h00; set_frames = 8'h00;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R1 reset state", 32'h0);
    t_run_from_zero();
    t_boundary("R3 frames 09 to 10", 0, 0, 0, 9);
    t_boundary("R3 frames 19 to 20", 0, 0, 0, 19);
    t_boundary("R5 seconds 09 to 10", 0, 0, 9, 29);
    t_boundary("R5 seconds wrap", 0, 0, 59, 29);
    t_boundary("R6 minutes 09 to 10", 0, 9, 59, 29);
    t_boundary("R6 minutes wrap", 0, 59, 59, 29);
    t_boundary("R7 hours 09 to 10", 9, 59, 59, 29);
    t_boundary("R7 hours 19 to 20", 19, 59, 59, 29);
    t_boundary("R7 full day wrap", 23, 59, 59, 29);
    t_hold();
    t_timing();
    t_load_priority();
    t_reset_priority();
    finish_run();
  end
endmodule